// File: doc/BRIEF.md
# Execute-Stage Operand and Address Generator

This unit sits in the execute stage of a small 32-bit load/store processor. It takes the decoded instruction word, the current program counter and the two values read from the register file. For a memory operation it forms the effective address. For an operation that writes a register it forms the write-back value. It also says which of three actions the instruction needs: a memory read, a memory write or a register write.

The instruction word has a fixed layout. The opcode sits in bits 31:27 and the destination/source register `ra` in bits 26:22. The base register `rb` sits in bits 21:17, with a 17-bit displacement in bits 16:0. PC-relative forms instead use a 22-bit constant in bits 21:0. When the base field of a displacement-form memory instruction holds zero, the base is a literal zero and not register 0. So a single encoding covers both direct and indexed addressing.

All results are captured in one register stage. The register file, the memory, shifts, branches and pipeline control belong to other blocks.

Top module: `opnd_agen`

## Requirements
- R1: Every output is registered and reflects the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` forces every output to zero at the next edge.
- R2: For opcodes 1, 3 and 5, a zero `rb` field (bits 21:17) selects a base of zero. Any non-zero `rb` selects `rb_val_i` as the base.
- R3: The 17-bit displacement in bits 16:0 is sign-extended to 32 bits before it is added. Results wrap modulo 2^32.
- R4: Opcode 1 (load) sets `mem_rd_o`, drives `addr_o` = base + displacement and drives `dst_o` = `ra` (bits 26:22).
- R5: Opcode 3 (store) sets `mem_wr_o`, drives `addr_o` = base + displacement and drives `wdata_o` = `ra_val_i`.
- R6: Opcode 5 (load address) sets `reg_wr_o`, drives `wb_val_o` = base + displacement and drives `dst_o` = `ra`.
- R7: Opcodes 2 and 4 set `mem_rd_o` or `mem_wr_o` respectively, with `addr_o` = `pc_i` + the sign-extended 22-bit constant in bits 21:0. Opcode 4 also drives `wdata_o` = `ra_val_i`, and opcode 2 drives `dst_o` = `ra`.
- R8: Opcode 6 sets `reg_wr_o` and drives `wb_val_o` = `pc_i` + the sign-extended 22-bit constant.
- R9: Opcodes 13, 21 and 23 set `reg_wr_o`. They drive `wb_val_o` = `rb_val_i` plus, AND or OR (in that opcode order) the sign-extended displacement. `rb_val_i` is used even when `rb` is zero.
- R10: Opcodes 0 and 31 raise no strobe and leave all data outputs zero. Opcode 31 sets `halt_o`.
- R11: Any other opcode sets `illegal_o`, raises no strobe and leaves every data output zero.
- R12: At most one of `mem_rd_o`, `mem_wr_o` and `reg_wr_o` is set at a time. Unused outputs read zero: `addr_o` outside memory operations, `wdata_o` outside writes, `wb_val_o` outside register writes, and `dst_o` outside memory reads and register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | XLEN | Instruction word |
| pc_i | input | XLEN | Program counter of the instruction |
| rb_val_i | input | XLEN | Register file value selected by `rb` |
| ra_val_i | input | XLEN | Register file value selected by `ra` (store data) |
| addr_o | output | XLEN | Memory effective address |
| wdata_o | output | XLEN | Store data |
| wb_val_o | output | XLEN | Register write-back value |
| dst_o | output | REG_W | Destination register of a read or register write |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| reg_wr_o | output | 1 | Register write strobe |
| halt_o | output | 1 | Halt request |
| illegal_o | output | 1 | Unrecognised opcode |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 5-bit opcode and 5-bit register fields. These defaults yield a 17-bit displacement and a 22-bit PC-relative constant. The bench therefore reaches the sign bit of both constants and the 32-bit wrap of the adder, including a negative constant added to a small PC and a negative displacement added to a small base. It also gives the base field both its zero value and non-zero values, for the memory forms and for the immediate ALU forms. This separates the literal-zero base from register-file data.

// File: rtl/opnd_agen_pkg.sv
package opnd_agen_pkg;

    // Opcode values (numeric, sized at the use site)
    localparam int unsigned OPC_NOP  = 0;
    localparam int unsigned OPC_LD   = 1;
    localparam int unsigned OPC_LDR  = 2;
    localparam int unsigned OPC_ST   = 3;
    localparam int unsigned OPC_STR  = 4;
    localparam int unsigned OPC_LA   = 5;
    localparam int unsigned OPC_LAR  = 6;
    localparam int unsigned OPC_ADDI = 13;
    localparam int unsigned OPC_ANDI = 21;
    localparam int unsigned OPC_ORI  = 23;
    localparam int unsigned OPC_STOP = 31;

    // Which operand pair feeds the adder
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PCREL = 2'd1,
        SRC_DISP  = 2'd2,
        SRC_REG   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_OR  = 2'd2
    } alu_e;

    typedef struct packed {
        src_e src;
        alu_e alu;
        logic mem_rd;
        logic mem_wr;
        logic reg_wr;
        logic halt;
        logic illegal;
    } ctrl_t;

endpackage

// File: rtl/opnd_agen_decode.sv
module opnd_agen_decode
    import opnd_agen_pkg::*;
#(
    parameter int unsigned OP_W = 5
) (
    input  logic [OP_W-1:0] op_i,
    output ctrl_t           ctrl_o
);

    always_comb begin
        ctrl_o         = '0;
        ctrl_o.src     = SRC_NONE;
        ctrl_o.alu     = ALU_ADD;
        case (op_i)
            OP_W'(OPC_NOP): begin
            end
            OP_W'(OPC_STOP): begin
                ctrl_o.halt = 1'b1;
            end
            OP_W'(OPC_LD): begin
                ctrl_o.src    = SRC_DISP;
                ctrl_o.mem_rd = 1'b1;
            end
            OP_W'(OPC_ST): begin
                ctrl_o.src    = SRC_DISP;
                ctrl_o.mem_wr = 1'b1;
            end
            OP_W'(OPC_LA): begin
                ctrl_o.src    = SRC_DISP;
                ctrl_o.reg_wr = 1'b1;
            end
            OP_W'(OPC_LDR): begin
                ctrl_o.src    = SRC_PCREL;
                ctrl_o.mem_rd = 1'b1;
            end
            OP_W'(OPC_STR): begin
                ctrl_o.src    = SRC_PCREL;
                ctrl_o.mem_wr = 1'b1;
            end
            OP_W'(OPC_LAR): begin
                ctrl_o.src    = SRC_PCREL;
                ctrl_o.reg_wr = 1'b1;
            end
            OP_W'(OPC_ADDI): begin
                ctrl_o.src    = SRC_REG;
                ctrl_o.reg_wr = 1'b1;
            end
            OP_W'(OPC_ANDI): begin
                ctrl_o.src    = SRC_REG;
                ctrl_o.alu    = ALU_AND;
                ctrl_o.reg_wr = 1'b1;
            end
            OP_W'(OPC_ORI): begin
                ctrl_o.src    = SRC_REG;
                ctrl_o.alu    = ALU_OR;
                ctrl_o.reg_wr = 1'b1;
            end
            default: begin
                ctrl_o.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/opnd_agen_sext.sv
module opnd_agen_sext #(
    parameter int unsigned IN_W  = 17,
    parameter int unsigned OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);

    localparam int unsigned PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W == 0) begin : g_same
            assign val_o = val_i;
        end else begin : g_pad
            assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
        end
    endgenerate

endmodule

// File: rtl/opnd_agen_alu.sv
module opnd_agen_alu
    import opnd_agen_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_e         op_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] res_o
);

    always_comb begin
        sum_o = a_i + b_i;
        case (op_i)
            ALU_AND: res_o = a_i & b_i;
            ALU_OR:  res_o = a_i | b_i;
            default: res_o = sum_o;
        endcase
    end

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
    import opnd_agen_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OP_W  = 5,
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [XLEN-1:0]  instr_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  rb_val_i,
    input  logic [XLEN-1:0]  ra_val_i,
    output logic [XLEN-1:0]  addr_o,
    output logic [XLEN-1:0]  wdata_o,
    output logic [XLEN-1:0]  wb_val_o,
    output logic [REG_W-1:0] dst_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             reg_wr_o,
    output logic             halt_o,
    output logic             illegal_o
);

    // Field geometry derived from the word and field widths
    localparam int unsigned OP_LSB = XLEN - OP_W;
    localparam int unsigned RA_LSB = OP_LSB - REG_W;
    localparam int unsigned RB_LSB = RA_LSB - REG_W;
    localparam int unsigned DISP_W = RB_LSB;
    localparam int unsigned REL_W  = RA_LSB;

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  wdata;
        logic [XLEN-1:0]  wb_val;
        logic [REG_W-1:0] dst;
        logic             mem_rd;
        logic             mem_wr;
        logic             reg_wr;
        logic             halt;
        logic             illegal;
    } out_t;

    logic [OP_W-1:0]   op_w;
    logic [REG_W-1:0]  ra_w;
    logic [REG_W-1:0]  rb_w;
    logic [DISP_W-1:0] disp_w;
    logic [REL_W-1:0]  rel_w;

    assign op_w   = instr_i[XLEN-1:OP_LSB];
    assign ra_w   = instr_i[OP_LSB-1:RA_LSB];
    assign rb_w   = instr_i[RA_LSB-1:RB_LSB];
    assign disp_w = instr_i[DISP_W-1:0];
    assign rel_w  = instr_i[REL_W-1:0];

    ctrl_t           ctrl_w;
    logic [XLEN-1:0] disp_x_w;
    logic [XLEN-1:0] rel_x_w;
    logic [XLEN-1:0] base_w;
    logic [XLEN-1:0] opa_w;
    logic [XLEN-1:0] opb_w;
    logic [XLEN-1:0] sum_w;
    logic [XLEN-1:0] res_w;

    opnd_agen_decode #(
        .OP_W (OP_W)
    ) u_decode (
        .op_i   (op_w),
        .ctrl_o (ctrl_w)
    );

    opnd_agen_sext #(
        .IN_W  (DISP_W),
        .OUT_W (XLEN)
    ) u_sext_disp (
        .val_i (disp_w),
        .val_o (disp_x_w)
    );

    opnd_agen_sext #(
        .IN_W  (REL_W),
        .OUT_W (XLEN)
    ) u_sext_rel (
        .val_i (rel_w),
        .val_o (rel_x_w)
    );

    // Base selection: literal zero only for the displacement memory group
    always_comb begin
        if ((ctrl_w.src == SRC_DISP) && (rb_w == '0)) begin
            base_w = '0;
        end else begin
            base_w = rb_val_i;
        end
        if (ctrl_w.src == SRC_PCREL) begin
            opa_w = pc_i;
            opb_w = rel_x_w;
        end else begin
            opa_w = base_w;
            opb_w = disp_x_w;
        end
    end

    opnd_agen_alu #(
        .W (XLEN)
    ) u_alu (
        .a_i   (opa_w),
        .b_i   (opb_w),
        .op_i  (ctrl_w.alu),
        .sum_o (sum_w),
        .res_o (res_w)
    );

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d         = '0;
        out_d.mem_rd  = ctrl_w.mem_rd;
        out_d.mem_wr  = ctrl_w.mem_wr;
        out_d.reg_wr  = ctrl_w.reg_wr;
        out_d.halt    = ctrl_w.halt;
        out_d.illegal = ctrl_w.illegal;
        if (ctrl_w.mem_rd || ctrl_w.mem_wr) begin
            out_d.addr = sum_w;
        end
        if (ctrl_w.mem_wr) begin
            out_d.wdata = ra_val_i;
        end
        if (ctrl_w.reg_wr) begin
            out_d.wb_val = res_w;
        end
        if (ctrl_w.mem_rd || ctrl_w.reg_wr) begin
            out_d.dst = ra_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_o    = out_q.addr;
    assign wdata_o   = out_q.wdata;
    assign wb_val_o  = out_q.wb_val;
    assign dst_o     = out_q.dst;
    assign mem_rd_o  = out_q.mem_rd;
    assign mem_wr_o  = out_q.mem_wr;
    assign reg_wr_o  = out_q.reg_wr;
    assign halt_o    = out_q.halt;
    assign illegal_o = out_q.illegal;

endmodule

// File: rtl/opnd_agen_chk.sv
module opnd_agen_chk
    import opnd_agen_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OP_W  = 5,
    parameter int unsigned REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  instr_i,
    input logic [XLEN-1:0]  pc_i,
    input logic [XLEN-1:0]  rb_val_i,
    input logic [XLEN-1:0]  ra_val_i,
    input logic [XLEN-1:0]  addr_o,
    input logic [XLEN-1:0]  wdata_o,
    input logic [XLEN-1:0]  wb_val_o,
    input logic [REG_W-1:0] dst_o,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic             reg_wr_o,
    input logic             halt_o,
    input logic             illegal_o
);

    localparam int unsigned OP_LSB = XLEN - OP_W;
    localparam int unsigned RA_LSB = OP_LSB - REG_W;
    localparam int unsigned RB_LSB = RA_LSB - REG_W;
    localparam int unsigned DISP_W = RB_LSB;
    localparam int unsigned REL_W  = RA_LSB;

    logic [OP_W-1:0]  c_op;
    logic [REG_W-1:0] c_ra;
    logic [REG_W-1:0] c_rb;
    logic [XLEN-1:0]  c_disp;
    logic [XLEN-1:0]  c_rel;

    assign c_op   = instr_i[XLEN-1:OP_LSB];
    assign c_ra   = instr_i[OP_LSB-1:RA_LSB];
    assign c_rb   = instr_i[RA_LSB-1:RB_LSB];
    assign c_disp = {{(XLEN-DISP_W){instr_i[DISP_W-1]}}, instr_i[DISP_W-1:0]};
    assign c_rel  = {{(XLEN-REL_W){instr_i[REL_W-1]}}, instr_i[REL_W-1:0]};

    // Set once a non-reset cycle has been sampled
    logic armed_q;
    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mem_rd_o && !mem_wr_o && !reg_wr_o && !halt_o && !illegal_o && addr_o == '0); // R1

    AST_DIRECT_ZERO_BASE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(c_op) == OP_W'(OPC_LD) && $past(c_rb) == '0) |-> addr_o == $past(c_disp)); // R2

    AST_INDEXED_BASE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(c_op) == OP_W'(OPC_LD) && $past(c_rb) != '0) |-> addr_o == $past(rb_val_i) + $past(c_disp)); // R4

    AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
        (armed_q && mem_wr_o) |-> wdata_o == $past(ra_val_i)); // R5

    AST_PC_RELATIVE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(c_op) == OP_W'(OPC_LDR)) |-> mem_rd_o && addr_o == $past(pc_i) + $past(c_rel)); // R7

    AST_REG_DEST: assert property (@(posedge clk) disable iff (rst)
        (armed_q && reg_wr_o) |-> dst_o == $past(c_ra)); // R6

    AST_HALT_STOP: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> halt_o == ($past(c_op) == OP_W'(OPC_STOP))); // R10

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !mem_rd_o && !mem_wr_o && !reg_wr_o && !halt_o && addr_o == '0); // R11

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_o, mem_wr_o, reg_wr_o})); // R12

    AST_IDLE_WB_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_o |-> wb_val_o == '0); // R12

endmodule

bind opnd_agen opnd_agen_chk #(
    .XLEN  (XLEN),
    .OP_W  (OP_W),
    .REG_W (REG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .rb_val_i  (rb_val_i),
    .ra_val_i  (ra_val_i),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o),
    .wb_val_o  (wb_val_o),
    .dst_o     (dst_o),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .reg_wr_o  (reg_wr_o),
    .halt_o    (halt_o),
    .illegal_o (illegal_o)
);

// File: tb/opnd_agen_bench.sv
module opnd_agen_bench;

    localparam int unsigned NV = 22;
    localparam logic [31:0] PC0 = 32'h0000_1000;
    localparam logic [31:0] RAV = 32'hCAFE_0001;
    // flag order {mem_rd, mem_wr, reg_wr, halt, illegal}
    localparam logic [4:0] F_RD = 5'b10000;
    localparam logic [4:0] F_WR = 5'b01000;
    localparam logic [4:0] F_RW = 5'b00100;
    localparam logic [4:0] F_HT = 5'b00010;
    localparam logic [4:0] F_IL = 5'b00001;
    localparam logic [4:0] F_NO = 5'b00000;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic [31:0] rbv;
        logic [31:0] rav;
        logic [31:0] e_addr;
        logic [31:0] e_wd;
        logic [31:0] e_wb;
        logic [4:0]  e_dst;
        logic [4:0]  e_flags;
        logic [3:0]  req;
    } vec_t;

    function automatic logic [31:0] encd(input logic [4:0] op, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic [16:0] c2);
        return {op, ra, rb, c2};
    endfunction

    function automatic logic [31:0] encr(input logic [4:0] op, input logic [4:0] ra,
                                         input logic [21:0] c1);
        return {op, ra, c1};
    endfunction

    // Every row also checks that unused outputs stay zero (R12)
    localparam vec_t VECS [NV] = '{
        // R4 R2: direct load, base forced to zero although rbv is non-zero
        '{encd(5'd1, 5'd3, 5'd0, 17'h00038), PC0, 32'h200, RAV, 32'h38, 32'h0, 32'h0, 5'd3, F_RD, 4'd4},
        // R2: indexed load
        '{encd(5'd1, 5'd3, 5'd5, 17'h00038), PC0, 32'h200, RAV, 32'h238, 32'h0, 32'h0, 5'd3, F_RD, 4'd2},
        // R3: negative direct displacement
        '{encd(5'd1, 5'd1, 5'd0, 17'h1FFFC), PC0, 32'h200, RAV, 32'hFFFF_FFFC, 32'h0, 32'h0, 5'd1, F_RD, 4'd3},
        // R5: indexed store
        '{encd(5'd3, 5'd8, 5'd6, 17'h00022), PC0, 32'h200, RAV, 32'h222, RAV, 32'h0, 5'd0, F_WR, 4'd5},
        // R2: direct store
        '{encd(5'd3, 5'd8, 5'd0, 17'h00022), PC0, 32'h200, RAV, 32'h22, RAV, 32'h0, 5'd0, F_WR, 4'd2},
        // R6: load address, zero base
        '{encd(5'd5, 5'd3, 5'd0, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h38, 5'd3, F_RW, 4'd6},
        // R6: load address, indexed
        '{encd(5'd5, 5'd3, 5'd5, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h238, 5'd3, F_RW, 4'd6},
        // R7: PC-relative load
        '{encr(5'd2, 5'd3, 22'h000038), PC0, 32'h200, RAV, 32'h1038, 32'h0, 32'h0, 5'd3, F_RD, 4'd7},
        // R7: PC-relative store
        '{encr(5'd4, 5'd8, 22'h000022), PC0, 32'h200, RAV, 32'h1022, RAV, 32'h0, 5'd0, F_WR, 4'd7},
        // R8: PC-relative address, negative constant
        '{encr(5'd6, 5'd3, 22'h3FFFF8), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'hFF8, 5'd3, F_RW, 4'd8},
        // R9: add immediate
        '{encd(5'd13, 5'd3, 5'd4, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h238, 5'd3, F_RW, 4'd9},
        // R9: add immediate, rb zero still uses rb_val_i, displacement -1
        '{encd(5'd13, 5'd3, 5'd0, 17'h1FFFF), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h1FF, 5'd3, F_RW, 4'd9},
        // R9: AND immediate, positive
        '{encd(5'd21, 5'd3, 5'd4, 17'h000F0), PC0, 32'h1234_5678, RAV, 32'h0, 32'h0, 32'h70, 5'd3, F_RW, 4'd9},
        // R9 R3: AND immediate, sign-extended mask
        '{encd(5'd21, 5'd3, 5'd4, 17'h1FF00), PC0, 32'h1234_5678, RAV, 32'h0, 32'h0, 32'h1234_5600, 5'd3, F_RW, 4'd9},
        // R9: OR immediate, positive
        '{encd(5'd23, 5'd3, 5'd4, 17'h0000F), PC0, 32'h1234_5670, RAV, 32'h0, 32'h0, 32'h1234_567F, 5'd3, F_RW, 4'd9},
        // R9 R3: OR immediate, sign-extended
        '{encd(5'd23, 5'd3, 5'd4, 17'h10000), PC0, 32'h0000_1234, RAV, 32'h0, 32'h0, 32'hFFFF_1234, 5'd3, F_RW, 4'd9},
        // R10: no-op with non-zero fields
        '{encd(5'd0, 5'd3, 5'd4, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h0, 5'd0, F_NO, 4'd10},
        // R10: stop
        '{encd(5'd31, 5'd3, 5'd4, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h0, 5'd0, F_HT, 4'd10},
        // R11: shift opcode is outside this unit
        '{encd(5'd26, 5'd3, 5'd4, 17'h00007), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h0, 5'd0, F_IL, 4'd11},
        // R11: unassigned opcode
        '{encd(5'd7, 5'd3, 5'd4, 17'h00038), PC0, 32'h200, RAV, 32'h0, 32'h0, 32'h0, 5'd0, F_IL, 4'd11},
        // R3: negative displacement on indexed store
        '{encd(5'd3, 5'd2, 5'd5, 17'h1FFF0), PC0, 32'h200, RAV, 32'h1F0, RAV, 32'h0, 5'd0, F_WR, 4'd3},
        // R7: negative PC-relative constant
        '{encr(5'd2, 5'd1, 22'h3FFFFC), PC0, 32'h200, RAV, 32'hFFC, 32'h0, 32'h0, 5'd1, F_RD, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] rb_val_i = '0;
    logic [31:0] ra_val_i = '0;
    logic [31:0] addr_o;
    logic [31:0] wdata_o;
    logic [31:0] wb_val_o;
    logic [4:0]  dst_o;
    logic        mem_rd_o;
    logic        mem_wr_o;
    logic        reg_wr_o;
    logic        halt_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_bad    = 0;

    always #4 clk = ~clk;

    opnd_agen u_opnd_agen (
        .clk       (clk),
        .rst       (rst),
        .instr_i   (instr_i),
        .pc_i      (pc_i),
        .rb_val_i  (rb_val_i),
        .ra_val_i  (ra_val_i),
        .addr_o    (addr_o),
        .wdata_o   (wdata_o),
        .wb_val_o  (wb_val_o),
        .dst_o     (dst_o),
        .mem_rd_o  (mem_rd_o),
        .mem_wr_o  (mem_wr_o),
        .reg_wr_o  (reg_wr_o),
        .halt_o    (halt_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [105:0] snap();
        return {addr_o, wdata_o, wb_val_o, dst_o,
                mem_rd_o, mem_wr_o, reg_wr_o, halt_o, illegal_o};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [105:0] act, input logic [105:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        instr_i  = v.instr;
        pc_i     = v.pc;
        rb_val_i = v.rbv;
        ra_val_i = v.rav;
    endtask

    function automatic logic [105:0] expect_of(input vec_t v);
        return {v.e_addr, v.e_wd, v.e_wb, v.e_dst, v.e_flags};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        logic [105:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(snap() == '0, "R1", "reset state", snap(), '0);

        rst = 1'b0;
        for (int i = 0; i < int'(NV); i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check(snap() == expect_of(VECS[i]), $sformatf("R%0d", VECS[i].req),
                  $sformatf("vector %0d", i), snap(), expect_of(VECS[i]));
        end

        // R1: one-cycle latency, output holds until the next edge
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        held = snap();
        drive(VECS[16]);
        #1;
        check(snap() == held, "R1", "output held before edge", snap(), held);
        @(negedge clk);
        check(snap() == '0, "R1", "new value after edge", snap(), '0);

        // R1: synchronous reset clears a live load
        drive(VECS[7]);
        rst = 1'b1;
        @(negedge clk);
        check(snap() == '0, "R1", "reset over load", snap(), '0);
        rst = 1'b0;
        @(negedge clk);
        check(snap() == expect_of(VECS[7]), "R7", "resume after reset", snap(), expect_of(VECS[7]));

        // R11 then R4: illegal followed directly by a legal load recovers
        drive(VECS[19]);
        @(negedge clk);
        check(snap() == expect_of(VECS[19]), "R11", "illegal back-to-back", snap(), expect_of(VECS[19]));
        drive(VECS[1]);
        @(negedge clk);
        check(snap() == expect_of(VECS[1]), "R4", "load after illegal", snap(), expect_of(VECS[1]));

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule